// File: doc/BRIEF.md
# Dual-Tone Alert Guard-Time Qualifier

An upstream tone detector raises a flag while both tones of a dual-tone alert are present. On its own, that flag is unreliable: speech and brief noise can produce short bursts that look like the alert. This block counts system clock cycles to turn the flag into a qualified steering output. The output is asserted only after the tone has been held for a present guard time. It is released only after the tone has been gone for an absent guard time. The two guard times are separate parameters, so recognition and release can be tuned independently.

A second stage watches the same raw flag and judges each tone burst as a whole. A burst may contain short gaps of up to a set number of cycles. It ends at the first gap that is longer than that. When a burst ends, the block reports whether its duration fell inside the allowed window. A burst that runs past the maximum duration is reported as invalid at that moment. The stage is selected by a parameter, and when it is left out its outputs are tied low.

While the enable input is low the block is powered down. In that state the steering output is held inactive, the early flag is held low, and all timers are cleared.

Top module: `tone_guard_qualifier`

## Requirements
- R1: `tone_early` follows `tone_raw` combinationally while `det_en` is high and is 0 while `det_en` is low.
- R2: In the cycle after a synchronous reset, `alert_n` is 1 and both `pulse_done` and `pulse_valid` are 0.
- R3: `alert_n` falls just after the clock edge at which `tone_raw` is sampled high for the PRESENT_CYC-th consecutive time.
- R4: A single low sample of `tone_raw` before the present guard expires restarts the present count from zero, so a burst shorter than PRESENT_CYC never drives `alert_n` low.
- R5: Once `alert_n` is low, it returns to 1 just after the edge at which `tone_raw` is sampled low for the ABSENT_CYC-th consecutive time. A high sample restarts that count. Only after the release can a new alert be recognised.
- R6: The present and absent guard times come from two independent parameters and may differ.
- R7: While `det_en` is low, `alert_n` is 1 and the guard count is cleared. After re-enabling, a full present guard time is needed again.
- R8: A run of at most MAX_DROP consecutive low samples inside a burst does not end it. The burst ends at the (MAX_DROP+1)-th consecutive low sample, and `pulse_done` is 1 for the cycle that follows that edge.
- R9: The duration of a burst counts the cycles from its first high sample to its last high sample, including any gaps between them. When a burst ends by dropout, `pulse_valid` is 1 if the duration is at least MIN_PULSE and 0 otherwise.
- R10: When the duration would exceed MAX_PULSE, `pulse_done` rises with `pulse_valid` = 0 at that edge. No further report follows until the tone has dropped out for more than MAX_DROP cycles and a new burst has started.
- R11: `pulse_done` lasts a single cycle. `pulse_valid` changes only together with `pulse_done` and otherwise holds its last verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| det_en | input | 1 | Detection enable; low selects power-down |
| tone_raw | input | 1 | Raw dual-tone present flag, active high |
| tone_early | output | 1 | Early steering flag, active high |
| alert_n | output | 1 | Guard-time qualified steering output, active low |
| pulse_done | output | 1 | One-cycle strobe when a burst has been judged |
| pulse_valid | output | 1 | Verdict of the last judged burst (1 = within limits) |

## Verification
On every cycle, the assertions check four things. The qualified output may only assert after a high sample and release after a low sample. Power-down empties the guard state. The dropout and duration counters never pass their limits, and the verdict changes only together with its strobe. The exact cycle counts need the bench's directed scenarios: the edge at which the output falls or rises, the restart after a glitch, the gap that ends a burst, the MIN_PULSE boundary, and the silent recovery after an overlong burst.

// File: rtl/tgq_pkg.sv
`timescale 1ns/1ps
package tgq_pkg;

  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_ACTIVE = 2'd1,
    PS_GAP    = 2'd2,
    PS_OVER   = 2'd3
  } pulse_state_t;

  function automatic int cnt_bits(input int limit);
    int b;
    b = 1;
    while ((1 << b) <= limit) b++;
    return b;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/tgq_guard.sv
`timescale 1ns/1ps
module tgq_guard #(
  parameter int PRESENT_CYC = 8,
  parameter int ABSENT_CYC  = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic raw,
  output logic qual
);
  import tgq_pkg::*;

  localparam int LIMIT = max2(PRESENT_CYC, ABSENT_CYC);
  localparam int CW    = cnt_bits(LIMIT);
  localparam logic [CW-1:0] P_LAST = CW'(PRESENT_CYC - 1);
  localparam logic [CW-1:0] A_LAST = CW'(ABSENT_CYC - 1);

  logic [CW-1:0] cnt;
  logic          qual_r;

  // One counter serves both directions: it integrates samples that disagree
  // with the current state and restarts on any sample that agrees with it.
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      qual_r <= 1'b0;
      cnt    <= '0;
    end else if (!qual_r) begin
      if (raw) begin
        if (cnt == P_LAST) begin
          qual_r <= 1'b1;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end else begin
      if (!raw) begin
        if (cnt == A_LAST) begin
          qual_r <= 1'b0;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
      end
    end
  end

  assign qual = qual_r;

  AST_QUAL_AFTER_HIGH: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_r) |-> ($past(raw) && $past(en)));                       // R3
  AST_RELEASE_AFTER_LOW: assert property (@(posedge clk) disable iff (rst)
    ($fell(qual_r) && $past(en)) |-> !$past(raw));                      // R5
  AST_PWDN_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!qual_r && cnt == '0));                                    // R7
  AST_GUARD_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt < CW'(LIMIT));                                                  // R6

endmodule

// File: rtl/tgq_pulse_check.sv
`timescale 1ns/1ps
module tgq_pulse_check #(
  parameter int MIN_PULSE = 12,
  parameter int MAX_PULSE = 40,
  parameter int MAX_DROP  = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic raw,
  output logic done,
  output logic valid
);
  import tgq_pkg::*;

  localparam int LW = cnt_bits(MAX_PULSE);
  localparam int DW = cnt_bits(MAX_DROP);
  localparam logic [LW:0]   LEN_MAX = (LW+1)'(MAX_PULSE);
  localparam logic [LW-1:0] LEN_MIN = LW'(MIN_PULSE);
  localparam logic [DW-1:0] GAP_MAX = DW'(MAX_DROP);

  pulse_state_t  st;
  logic [LW-1:0] len;   // first high sample to latest high sample, inclusive
  logic [DW-1:0] gap;   // consecutive low samples in the current gap
  logic [LW:0]   len_resume;
  logic          done_r, valid_r;

  // A resumed tone absorbs the gap into the burst duration.
  assign len_resume = {1'b0, len} + (LW+1)'(gap) + (LW+1)'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= PS_IDLE;
      len     <= '0;
      gap     <= '0;
      done_r  <= 1'b0;
      valid_r <= 1'b0;
    end else if (!en) begin
      st     <= PS_IDLE;
      len    <= '0;
      gap    <= '0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      unique case (st)
        PS_IDLE: begin
          gap <= '0;
          if (raw) begin
            st  <= PS_ACTIVE;
            len <= LW'(1);
          end
        end
        PS_ACTIVE: begin
          if (raw) begin
            if ({1'b0, len} == LEN_MAX) begin
              st      <= PS_OVER;
              done_r  <= 1'b1;
              valid_r <= 1'b0;
              gap     <= '0;
            end else begin
              len <= len + 1'b1;
            end
          end else begin
            st  <= PS_GAP;
            gap <= DW'(1);
          end
        end
        PS_GAP: begin
          if (raw) begin
            if (len_resume > LEN_MAX) begin
              st      <= PS_OVER;
              done_r  <= 1'b1;
              valid_r <= 1'b0;
            end else begin
              st  <= PS_ACTIVE;
              len <= len_resume[LW-1:0];
            end
            gap <= '0;
          end else if (gap == GAP_MAX) begin
            st      <= PS_IDLE;
            done_r  <= 1'b1;
            valid_r <= (len >= LEN_MIN);
            gap     <= '0;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        PS_OVER: begin
          if (raw) begin
            gap <= '0;
          end else if (gap == GAP_MAX) begin
            st  <= PS_IDLE;
            gap <= '0;
          end else begin
            gap <= gap + 1'b1;
          end
        end
        default: st <= PS_IDLE;
      endcase
    end
  end

  assign done  = done_r;
  assign valid = valid_r;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_r |=> !done_r);                                                // R11
  AST_VERDICT_WITH_STROBE: assert property (@(posedge clk) disable iff (rst)
    !$stable(valid_r) |-> done_r);                                      // R11
  AST_GAP_BOUND: assert property (@(posedge clk) disable iff (rst)
    gap <= GAP_MAX);                                                    // R8
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    {1'b0, len} <= LEN_MAX);                                            // R10
  AST_OVER_INVALID: assert property (@(posedge clk) disable iff (rst)
    (st == PS_OVER && $past(st) != PS_OVER && $past(en)) |-> (done_r && !valid_r)); // R10

endmodule

// File: rtl/tone_guard_qualifier.sv
`timescale 1ns/1ps
module tone_guard_qualifier #(
  parameter int PRESENT_CYC = 40000,
  parameter int ABSENT_CYC  = 25000,
  parameter int CHECK_EN    = 1,
  parameter int MIN_PULSE   = 200000,
  parameter int MAX_PULSE   = 400000,
  parameter int MAX_DROP    = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic det_en,
  input  logic tone_raw,
  output logic tone_early,
  output logic alert_n,
  output logic pulse_done,
  output logic pulse_valid
);

  logic qual;

  assign tone_early = det_en & tone_raw;

  tgq_guard #(
    .PRESENT_CYC(PRESENT_CYC),
    .ABSENT_CYC (ABSENT_CYC)
  ) u_guard (
    .clk (clk),
    .rst (rst),
    .en  (det_en),
    .raw (tone_raw),
    .qual(qual)
  );

  // Power-down forces the steering output inactive without waiting an edge.
  assign alert_n = ~(qual & det_en);

  generate
    if (CHECK_EN != 0) begin : g_check
      tgq_pulse_check #(
        .MIN_PULSE(MIN_PULSE),
        .MAX_PULSE(MAX_PULSE),
        .MAX_DROP (MAX_DROP)
      ) u_check (
        .clk  (clk),
        .rst  (rst),
        .en   (det_en),
        .raw  (tone_raw),
        .done (pulse_done),
        .valid(pulse_valid)
      );
    end else begin : g_nocheck
      assign pulse_done  = 1'b0;
      assign pulse_valid = 1'b0;
    end
  endgenerate

  AST_PWDN_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    !det_en |-> (alert_n && !tone_early));                              // R7

endmodule

// File: tb/tone_guard_qualifier_test.sv
`timescale 1ns/1ps
module tone_guard_qualifier_test;

  localparam int P   = 8;
  localparam int A   = 5;
  localparam int MN  = 12;
  localparam int MX  = 40;
  localparam int DRP = 3;

  logic clk = 1'b0;
  logic rst, det_en, tone_raw;
  logic tone_early, alert_n, pulse_done, pulse_valid;
  int   n_chk = 0;
  int   n_bad = 0;

  always #10 clk = ~clk;

  tone_guard_qualifier #(
    .PRESENT_CYC(P), .ABSENT_CYC(A), .CHECK_EN(1),
    .MIN_PULSE(MN), .MAX_PULSE(MX), .MAX_DROP(DRP)
  ) uut (
    .clk(clk), .rst(rst), .det_en(det_en), .tone_raw(tone_raw),
    .tone_early(tone_early), .alert_n(alert_n),
    .pulse_done(pulse_done), .pulse_valid(pulse_valid)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; det_en = 1'b1; tone_raw = 1'b0;
    tick(2);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R2 alert_n", alert_n, 1);
    chk("R2 pulse_done", pulse_done, 0);
    chk("R2 pulse_valid", pulse_valid, 0);
  endtask

  task automatic t_early();
    do_reset();
    tone_raw = 1'b1; #1;
    chk("R1 early high", tone_early, 1);
    det_en = 1'b0; #1;
    chk("R1 early off when disabled", tone_early, 0);
    det_en = 1'b1; tone_raw = 1'b0; #1;
    chk("R1 early low", tone_early, 0);
  endtask

  task automatic t_present();
    do_reset();
    tone_raw = 1'b1;
    tick(P - 1);
    chk("R3 before present guard", alert_n, 1);
    tick(1);
    chk("R3 at present guard", alert_n, 0);
  endtask

  task automatic t_glitch();
    do_reset();
    tone_raw = 1'b1; tick(P - 1);
    tone_raw = 1'b0; tick(1);
    chk("R4 glitch no qualify", alert_n, 1);
    tone_raw = 1'b1; tick(P - 1);
    chk("R4 count restarted", alert_n, 1);
    tick(1);
    chk("R4 qualify after restart", alert_n, 0);
  endtask

  task automatic t_absent();
    do_reset();
    tone_raw = 1'b1; tick(P);
    tone_raw = 1'b0; tick(A - 1);
    chk("R5 held before absent guard", alert_n, 0);
    tone_raw = 1'b1; tick(1);
    tone_raw = 1'b0; tick(A - 1);
    chk("R6 absent count restarted", alert_n, 0);
    tick(1);
    chk("R5 release at absent guard", alert_n, 1);
    tone_raw = 1'b1; tick(P - 1);
    chk("R5 new alert needs full guard", alert_n, 1);
    tick(1);
    chk("R5 new alert accepted", alert_n, 0);
  endtask

  task automatic t_pwdn();
    do_reset();
    tone_raw = 1'b1; tick(P);
    det_en = 1'b0; #1;
    chk("R7 alert_n forced high", alert_n, 1);
    chk("R7 early forced low", tone_early, 0);
    tick(2);
    det_en = 1'b1;
    tick(P - 1);
    chk("R7 guard cleared by power-down", alert_n, 1);
    tick(1);
    chk("R7 requalified", alert_n, 0);
  endtask

  task automatic t_valid_min();
    do_reset();
    tone_raw = 1'b1; tick(MN);
    tone_raw = 1'b0; tick(DRP);
    chk("R8 gap of MAX_DROP keeps pulse", pulse_done, 0);
    tick(1);
    chk("R8 pulse ends after longer gap", pulse_done, 1);
    chk("R9 duration at MIN valid", pulse_valid, 1);
    tick(1);
    chk("R11 done single cycle", pulse_done, 0);
    chk("R11 verdict held", pulse_valid, 1);
  endtask

  task automatic t_short_with_gap();
    int seen;
    do_reset();
    seen = 0;
    tone_raw = 1'b1; tick(5);
    tone_raw = 1'b0;
    for (int i = 0; i < DRP; i++) begin tick(1); seen += pulse_done; end
    chk("R8 dropout tolerated", seen, 0);
    tone_raw = 1'b1; tick(3);
    tone_raw = 1'b0; tick(DRP + 1);
    chk("R8 short pulse reported", pulse_done, 1);
    chk("R9 duration 11 below MIN invalid", pulse_valid, 0);
  endtask

  task automatic t_overlong();
    int seen;
    do_reset();
    seen = 0;
    tone_raw = 1'b1;
    for (int i = 0; i < MX; i++) begin tick(1); seen += pulse_done; end
    chk("R10 no report up to MAX", seen, 0);
    tick(1);
    chk("R10 overlong reported", pulse_done, 1);
    chk("R10 overlong invalid", pulse_valid, 0);
    seen = 0;
    for (int i = 0; i < 10; i++) begin tick(1); seen += pulse_done; end
    tone_raw = 1'b0;
    for (int i = 0; i < DRP + 1; i++) begin tick(1); seen += pulse_done; end
    chk("R10 silent after overlong", seen, 0);
    tone_raw = 1'b1; tick(MN + 2);
    tone_raw = 1'b0; tick(DRP + 1);
    chk("R10 recovery pulse reported", pulse_done, 1);
    chk("R10 recovery pulse valid", pulse_valid, 1);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; det_en = 1'b0; tone_raw = 1'b0;
    t_reset();
    t_early();
    t_present();
    t_glitch();
    t_absent();
    t_pwdn();
    t_valid_min();
    t_short_with_gap();
    t_overlong();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule